// File: doc/BRIEF.md
# Cache Victim Way Selector

This block chooses which way of a set-associative cache receives the next line fill after a miss. Each time the cache controller pulses its allocate strobe, the selector moves on to a new victim way. Hits and idle cycles leave the choice unchanged. The chosen way is offered as a binary way number and as a one-hot way-enable vector, and both come straight from registers.

Two replacement policies are available. Round-robin steps through the ways in ascending order. Pseudorandom order comes from a small linear-feedback shift register. Both policies share a programmable floor way. Ways below the floor are never chosen, and when the sequence runs past the top way it returns to the floor. Software can therefore shield the lower ways from replacement, for example to lock content into them. Any change of policy or floor restarts the selection at the floor.

Top module: `victim_sel`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets victim_o to base_i and victim_oh_o to the vector with only bit base_i set, and seeds the 4-bit shift register with 4'b0001.
- R2: In a cycle with alloc_i low and no change of policy_i or base_i, victim_o and victim_oh_o keep their values at the next edge.
- R3: With policy_i = 0 (round-robin), an allocation while victim_o is below WAYS-1 makes victim_o equal to its old value plus one after the edge.
- R4: With policy_i = 0, an allocation while victim_o equals WAYS-1 reloads victim_o with base_i.
- R5: With policy_i = 1 (pseudorandom), an allocation first steps the shift register s to {s[2:0], s[3]^s[2]}. victim_o then becomes base_i + (new s[1:0] mod (WAYS - base_i)). The register changes only on an allocation accepted in pseudorandom mode.
- R6: With policy_i = 1 and base_i = WAYS-1, victim_o stays at WAYS-1 across any number of allocations.
- R7: When policy_i or base_i differs from its value at the previous edge, victim_o becomes base_i at the edge. An allocation in that cycle is ignored and the shift register holds.
- R8: victim_oh_o is always one-hot, and its set bit is bit victim_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Line-allocation strobe, one cycle per fill |
| policy_i | input | 1 | 0 round-robin, 1 pseudorandom |
| base_i | input | WAY_W | Lowest way that may be chosen |
| victim_o | output | WAY_W | Way number of the next victim |
| victim_oh_o | output | WAYS | One-hot form of victim_o |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. This holds for a reset, an allocation, an idle cycle, and a change of policy or floor. The bench therefore drives each input set on a falling edge and advances its own model by one step at the same moment. It compares both outputs with the model on the following falling edge, which sits half a period clear of the edge that moved them. Each comparison is tagged with the requirement that the preceding input set exercised, and every cycle also checks the one-hot output.

// File: rtl/victim_pkg.sv
package victim_pkg;
  typedef enum logic {
    POL_ROUND  = 1'b0,
    POL_RANDOM = 1'b1
  } policy_e;
endpackage

// File: rtl/victim_lfsr.sv
module victim_lfsr #(
  parameter int          LW   = 4,
  parameter logic [LW-1:0] TAPS = 4'b1100,
  parameter logic [LW-1:0] SEED = 4'b0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  output logic [LW-1:0] state_o,
  output logic [LW-1:0] next_o
);
  logic [LW-1:0] state_q;

  assign next_o  = {state_q[LW-2:0], ^(state_q & TAPS)};
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (rst)         state_q <= SEED;
    else if (step_i) state_q <= next_o;
  end

  // R5: a maximal-length register never reaches the all-zero lock-up state
  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/victim_next.sv
module victim_next
  import victim_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS),
  parameter int LW    = 4
) (
  input  policy_e          policy_i,
  input  logic [WAY_W-1:0] cur_i,
  input  logic [WAY_W-1:0] base_i,
  input  logic [LW-1:0]    rnd_i,
  output logic [WAY_W-1:0] nxt_o
);
  localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);

  logic [WAY_W:0]   span;
  logic [WAY_W:0]   pick;
  logic [WAY_W:0]   rem;
  logic [WAY_W-1:0] rr_nxt;
  logic [WAY_W-1:0] pr_nxt;

  genvar g;
  generate
    for (g = 0; g <= WAY_W; g++) begin : g_pick
      if (g < WAY_W) begin : g_bit
        assign pick[g] = rnd_i[g];
      end else begin : g_top
        assign pick[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    span   = (WAY_W+1)'(WAYS) - {1'b0, base_i};
    rem    = pick % span;
    pr_nxt = base_i + rem[WAY_W-1:0];
    rr_nxt = (cur_i == TOP) ? base_i : cur_i + WAY_W'(1);
    nxt_o  = (policy_i == POL_RANDOM) ? pr_nxt : rr_nxt;
  end
endmodule

// File: rtl/victim_onehot.sv
module victim_onehot #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAY_W-1:0] idx_i,
  output logic [WAYS-1:0]  oh_o
);
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_dec
      assign oh_o[w] = (idx_i == WAY_W'(w));
    end
  endgenerate
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS),
  parameter int LW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_i,
  input  logic             policy_i,
  input  logic [WAY_W-1:0] base_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [WAYS-1:0]  victim_oh_o
);
  localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);

  policy_e          pol;
  policy_e          pol_q;
  logic [WAY_W-1:0] base_q;
  logic [WAY_W-1:0] cnt_q;
  logic [WAY_W-1:0] cnt_d;
  logic [WAY_W-1:0] nxt;
  logic [WAYS-1:0]  oh_d;
  logic [WAYS-1:0]  oh_q;
  logic [LW-1:0]    rnd_state;
  logic [LW-1:0]    rnd_next;
  logic             chg;
  logic             step;

  assign pol  = policy_e'(policy_i);
  assign chg  = (pol != pol_q) || (base_i != base_q);
  assign step = !rst && !chg && alloc_i && (pol == POL_RANDOM);

  victim_lfsr #(.LW(LW)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .state_o (rnd_state),
    .next_o  (rnd_next)
  );

  victim_next #(.WAYS(WAYS), .WAY_W(WAY_W), .LW(LW)) u_next (
    .policy_i (pol),
    .cur_i    (cnt_q),
    .base_i   (base_i),
    .rnd_i    (rnd_next),
    .nxt_o    (nxt)
  );

  always_comb begin
    if (rst || chg)   cnt_d = base_i;
    else if (alloc_i) cnt_d = nxt;
    else              cnt_d = cnt_q;
  end

  victim_onehot #(.WAYS(WAYS), .WAY_W(WAY_W)) u_dec (
    .idx_i (cnt_d),
    .oh_o  (oh_d)
  );

  always_ff @(posedge clk) begin
    cnt_q  <= cnt_d;
    oh_q   <= oh_d;
    pol_q  <= pol;
    base_q <= base_i;
  end

  assign victim_o    = cnt_q;
  assign victim_oh_o = oh_q;

  // R8
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(oh_q) && oh_q[cnt_q]);
  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!alloc_i && !chg) |=> $stable(cnt_q));
  // R3
  a_r3_rr_step: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && !chg && pol == POL_ROUND && cnt_q != TOP)
      |=> cnt_q == $past(cnt_q) + WAY_W'(1));
  // R4
  a_r4_rr_wrap: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && !chg && pol == POL_ROUND && cnt_q == TOP)
      |=> cnt_q == $past(base_i));
  // R7
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    chg |=> cnt_q == $past(base_i));
  // R5: never below the floor
  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    cnt_q >= base_q);
  // R6
  a_r6_top_only: assert property (@(posedge clk) disable iff (rst)
    (base_q == TOP) |-> cnt_q == TOP);
endmodule

// File: tb/victim_sel_bench.sv
`timescale 1ns/1ps
module victim_sel_bench;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_i = 1'b0;
  logic       policy_i = 1'b0;
  logic [1:0] base_i = 2'd0;
  logic [1:0] victim_o;
  logic [3:0] victim_oh_o;

  int checks = 0;
  int errors = 0;
  int m_cnt, m_lfsr, m_pol, m_base;
  string tag;

  always #2.5 clk = ~clk;

  victim_sel u_victim_sel (
    .clk         (clk),
    .rst         (rst),
    .alloc_i     (alloc_i),
    .policy_i    (policy_i),
    .base_i      (base_i),
    .victim_o    (victim_o),
    .victim_oh_o (victim_oh_o)
  );

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // drive one input set at a falling edge, step the model, compare one edge later
  task automatic tick(input bit r, input bit a, input bit p, input int b);
    rst = r; alloc_i = a; policy_i = p; base_i = 2'(b);
    if (r) begin
      tag = "R1"; m_cnt = b; m_lfsr = 1; m_pol = p; m_base = b;
    end else if (p != m_pol || b != m_base) begin
      tag = "R7"; m_cnt = b; m_pol = p; m_base = b;
    end else if (!a) begin
      tag = "R2";
    end else if (p) begin
      tag = (b == WAYS-1) ? "R6" : "R5";
      m_lfsr = ((m_lfsr << 1) & 15) | (((m_lfsr >> 3) ^ (m_lfsr >> 2)) & 1);
      m_cnt = b + ((m_lfsr % 4) % (WAYS - b));
    end else begin
      tag = (m_cnt == WAYS-1) ? "R4" : "R3";
      m_cnt = (m_cnt == WAYS-1) ? b : m_cnt + 1;
    end
    @(negedge clk);
    check(tag, int'(victim_o), m_cnt);
    check("R8", int'(victim_oh_o), 1 << m_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(1, 0, 0, 0);                       // R1 reset to floor 0
    for (int i = 0; i < 6; i++) tick(0, 1, 0, 0);  // R3 steps, R4 wrap
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 0);  // R2 idle
    tick(0, 1, 0, 2);                       // R7 floor change, alloc ignored
    for (int i = 0; i < 5; i++) tick(0, 1, 0, 2);  // R3/R4 with floor 2
    tick(0, 1, 1, 0);                       // R7 policy change
    for (int i = 0; i < 20; i++) tick(0, 1, 1, 0); // R5 sequence
    tick(0, 0, 1, 1);                       // R7
    for (int i = 0; i < 12; i++) tick(0, i % 3 != 0, 1, 1); // R5, R2
    tick(0, 1, 1, 3);                       // R7
    for (int i = 0; i < 8; i++) tick(0, 1, 1, 3);  // R6
    tick(1, 0, 0, 1);                       // R1 reset with floor 1
    for (int i = 0; i < 200; i++) begin
      int b = (i % 37 == 0) ? int'($urandom_range(0, 3)) : m_base;
      int p = (i % 53 == 0) ? int'($urandom_range(0, 1)) : m_pol;
      tick(0, bit'($urandom_range(0, 1)), bit'(p), b);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule